// File: doc/BRIEF.md
# Optical Black Level Clamp Loop

This block keeps the black level of an image sensor pixel stream at a programmable code. It watches 12-bit samples from the converter. While a clamp-window input marks the shielded dark pixels of a line, it adds up the signed difference between each valid sample and the target. When the window closes, it turns that sum into a filtered mean. It scales the mean by a right-shift loop gain and subtracts the result from a stored correction. The correction is the code sent to the offset DAC in front of the converter, and this closes the loop.

The correction can be updated on every line or only on every Nth line. A control bit opens the loop. When the loop is open, the target register drives a fixed offset code to the DAC. The block also registers the pixel data for output. During blanking, the data output is forced to zero or to the target level. Three write-only registers configure the block: the control bits, the target level and the line divider.

Top module: `black_clamp_loop`

## Requirements
- R1: After reset the DAC code is mid-scale (512 for the default 10-bit DAC). The data output is 0, the target is 0, the loop is closed, the divider is 0 and blanking selects zero.
- R2: Only samples with `pix_valid` high while `clamp_win` is high are summed. Each sample adds the error `pix_code - target`. Samples outside the window have no effect on the correction.
- R3: At the first cycle with `clamp_win` low after a high one (the close), the block computes two values. With count c and sum s, it forms `r = (65536 + c/2) / c` and `mean = (s*r) >>> 16`. The loop step is `mean >>> 2`. The correction becomes `correction - step`. All shifts are arithmetic, so they round toward minus infinity. The DAC code shows the new value one clock after the close.
- R4: The correction saturates at 0 and at 1023 and never wraps.
- R5: A window with no valid samples leaves the correction unchanged.
- R6: The divider value D (address 2, bits 7:0) applies a measurement only on every (D+1)th close. Measurements at the other closes are discarded. Writing the divider restarts the line count.
- R7: Control register (address 0) bit 2 set to 1 opens the loop. While it is open, the DAC code is the low 10 bits of the target, and the correction holds its value and ignores closes. Clearing the bit brings back the held correction.
- R8: While `blank` is high on a valid sample, the data output is forced to 0 if control bit 0 is 0, or to the target if control bit 0 is 1.
- R9: The data output takes the sample (or its blanking value) one clock after a valid sample. It holds while `pix_valid` is low.
- R10: A target write (address 1, bits 11:0) made while the window is high takes effect only after the window closes. The window in progress is measured against the old target.
- R11: The sample count stops at 63. Valid samples beyond the 63rd in one window are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Sample strobe |
| pix_code | input | 12 | Converter sample |
| clamp_win | input | 1 | Dark-pixel clamp window |
| blank | input | 1 | Output blanking |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 control, 1 target, 2 divider |
| cfg_wdata | input | 12 | Register write data |
| dac_code | output | 10 | Offset correction code to the DAC |
| dout | output | 12 | Registered pixel output |

## Verification
The hardest states to reach are the ones where a window's measurement is deliberately not applied. These are the closes the divider skips, a window that is open while the loop is open, and a target write that arrives halfway through a window. Each of these happens at a single close edge and can only be seen through the DAC code. The bench therefore keeps its own model of the correction, the target in force and the line count. It drives whole windows of constant samples, including one that writes the target in the middle, and checks the DAC code one cycle after each close.

// File: rtl/black_clamp_pkg.sv
package black_clamp_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TGT  = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;
  localparam int CTRL_BLANK_BIT = 0;
  localparam int CTRL_OFF_BIT   = 2;

  typedef struct packed {
    logic loop_off;
    logic blank_to_tgt;
  } clamp_ctrl_t;
endpackage

// File: rtl/clamp_regs.sv
module clamp_regs
  import black_clamp_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [PIX_W-1:0] cfg_wdata,
  input  logic             win_i,
  output clamp_ctrl_t      ctrl_o,
  output logic [PIX_W-1:0] tgt_o,
  output logic [DIV_W-1:0] div_o,
  output logic             div_wr_o
);
  clamp_ctrl_t      ctrl_q, ctrl_d;
  logic [PIX_W-1:0] pend_q, pend_d, act_q, act_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             wr_ctrl, wr_tgt, wr_div;

  always_comb begin
    wr_ctrl = cfg_we && (cfg_addr == ADDR_CTRL);
    wr_tgt  = cfg_we && (cfg_addr == ADDR_TGT);
    wr_div  = cfg_we && (cfg_addr == ADDR_DIV);
    ctrl_d  = ctrl_q;
    pend_d  = pend_q;
    div_d   = div_q;
    if (wr_ctrl) begin
      ctrl_d.loop_off     = cfg_wdata[CTRL_OFF_BIT];
      ctrl_d.blank_to_tgt = cfg_wdata[CTRL_BLANK_BIT];
    end
    if (wr_tgt) pend_d = cfg_wdata;
    if (wr_div) div_d = cfg_wdata[DIV_W-1:0];
    act_d = win_i ? act_q : pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pend_q <= '0;
      act_q  <= '0;
      div_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      pend_q <= pend_d;
      act_q  <= act_d;
      div_q  <= div_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign tgt_o    = act_q;
  assign div_o    = div_q;
  assign div_wr_o = wr_div;

  assert_target_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    win_i |=> $stable(act_q));
endmodule

// File: rtl/clamp_accum.sv
module clamp_accum #(
  parameter int PIX_W = 12,
  parameter int CNT_W = 6,
  localparam int ERR_W = PIX_W + 1,
  localparam int SUM_W = ERR_W + CNT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    win_i,
  input  logic                    pix_valid,
  input  logic [PIX_W-1:0]        pix_code,
  input  logic [PIX_W-1:0]        tgt_i,
  output logic                    close_o,
  output logic signed [SUM_W-1:0] sum_o,
  output logic [CNT_W-1:0]        cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                    win_q;
  logic signed [SUM_W-1:0] sum_q, sum_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic signed [ERR_W-1:0] err;
  logic                    take, close;

  always_comb begin
    err   = $signed({1'b0, pix_code}) - $signed({1'b0, tgt_i});
    close = win_q && !win_i;
    take  = win_i && pix_valid && (cnt_q != CNT_MAX);
    sum_d = sum_q;
    cnt_d = cnt_q;
    if (close) begin
      sum_d = '0;
      cnt_d = '0;
    end else if (take) begin
      sum_d = sum_q + SUM_W'(err);
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      sum_q <= '0;
      cnt_q <= '0;
    end else begin
      win_q <= win_i;
      sum_q <= sum_d;
      cnt_q <= cnt_d;
    end
  end

  assign close_o = close;
  assign sum_o   = sum_q;
  assign cnt_o   = cnt_q;

  assert_clear_after_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> (cnt_q == '0 && sum_q == '0));
  assert_idle_no_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(win_i && pix_valid) && !close) |=> $stable(sum_q));
  assert_count_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !close) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/clamp_filter.sv
module clamp_filter #(
  parameter int DAC_W   = 10,
  parameter int SUM_W   = 19,
  parameter int CNT_W   = 6,
  parameter int FRAC    = 16,
  parameter int GAIN_SH = 2,
  parameter int DIV_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    close_i,
  input  logic                    loop_on_i,
  input  logic signed [SUM_W-1:0] sum_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [DIV_W-1:0]        div_i,
  input  logic                    div_wr_i,
  output logic [DAC_W-1:0]        corr_o
);
  localparam int CNT_N = 1 << CNT_W;
  localparam int RCP_W = FRAC + 1;
  localparam int PRD_W = SUM_W + RCP_W + 1;
  localparam int NW    = PRD_W - FRAC;
  localparam logic [DAC_W-1:0] CORR_MID = DAC_W'(1 << (DAC_W - 1));
  localparam logic signed [NW-1:0] CORR_TOP = NW'((1 << DAC_W) - 1);

  logic [RCP_W-1:0] rcp_lut [CNT_N];
  for (genvar g = 0; g < CNT_N; g++) begin : g_rcp
    if (g == 0) begin : g_zero
      assign rcp_lut[g] = '0;
    end else begin : g_val
      assign rcp_lut[g] = RCP_W'(((2 ** FRAC) + g / 2) / g);
    end
  end

  logic signed [PRD_W-1:0] prod;
  logic signed [NW-1:0]    mean, step, nxt;
  logic [DAC_W-1:0]        corr_q, corr_d;
  logic [DIV_W-1:0]        line_q, line_d;
  logic                    turn, apply;

  always_comb begin
    prod  = PRD_W'(sum_i) * PRD_W'($signed({1'b0, rcp_lut[cnt_i]}));
    mean  = NW'(prod >>> FRAC);
    step  = mean >>> GAIN_SH;
    nxt   = $signed({{(NW-DAC_W){1'b0}}, corr_q}) - step;
    turn  = close_i && loop_on_i;
    apply = turn && (line_q == div_i) && (cnt_i != '0);
    corr_d = corr_q;
    if (apply) begin
      if (nxt < 0)             corr_d = '0;
      else if (nxt > CORR_TOP) corr_d = '1;
      else                     corr_d = nxt[DAC_W-1:0];
    end
    line_d = line_q;
    if (div_wr_i)            line_d = '0;
    else if (turn)           line_d = (line_q == div_i) ? '0 : line_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_q <= CORR_MID;
      line_q <= '0;
    end else begin
      corr_q <= corr_d;
      line_q <= line_d;
    end
  end

  assign corr_o = corr_q;

  assert_corr_only_on_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(close_i && loop_on_i) |=> $stable(corr_q));
  assert_empty_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (close_i && cnt_i == '0) |=> $stable(corr_q));
  assert_open_loop_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_on_i |=> $stable(corr_q));
  assert_skip_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (close_i && line_q != div_i) |=> $stable(corr_q));
endmodule

// File: rtl/clamp_dout.sv
module clamp_dout #(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_code,
  input  logic             blank,
  input  logic             blank_to_tgt,
  input  logic [PIX_W-1:0] tgt_i,
  output logic [PIX_W-1:0] dout
);
  logic [PIX_W-1:0] dout_q, dout_d, fill;

  always_comb begin
    fill   = blank_to_tgt ? tgt_i : '0;
    dout_d = dout_q;
    if (pix_valid) dout_d = blank ? fill : pix_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign dout = dout_q;

  assert_dout_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> $stable(dout_q));
  assert_blank_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && blank && !blank_to_tgt) |=> dout_q == '0);
endmodule

// File: rtl/black_clamp_loop.sv
module black_clamp_loop
  import black_clamp_pkg::*;
#(
  parameter int PIX_W   = 12,
  parameter int DAC_W   = 10,
  parameter int CNT_W   = 6,
  parameter int FRAC    = 16,
  parameter int GAIN_SH = 2,
  parameter int DIV_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_code,
  input  logic             clamp_win,
  input  logic             blank,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [PIX_W-1:0] cfg_wdata,
  output logic [DAC_W-1:0] dac_code,
  output logic [PIX_W-1:0] dout
);
  localparam int SUM_W = PIX_W + 1 + CNT_W;

  logic [1:0]              rst_sync;
  logic                    rst_int_n;
  clamp_ctrl_t             ctrl;
  logic [PIX_W-1:0]        tgt;
  logic [DIV_W-1:0]        div;
  logic                    div_wr, close;
  logic signed [SUM_W-1:0] sum;
  logic [CNT_W-1:0]        cnt;
  logic [DAC_W-1:0]        corr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  clamp_regs #(.PIX_W(PIX_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .win_i(clamp_win), .ctrl_o(ctrl), .tgt_o(tgt),
    .div_o(div), .div_wr_o(div_wr));

  clamp_accum #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_accum (
    .clk(clk), .rst_n(rst_int_n), .win_i(clamp_win), .pix_valid(pix_valid),
    .pix_code(pix_code), .tgt_i(tgt), .close_o(close), .sum_o(sum), .cnt_o(cnt));

  clamp_filter #(.DAC_W(DAC_W), .SUM_W(SUM_W), .CNT_W(CNT_W), .FRAC(FRAC),
                 .GAIN_SH(GAIN_SH), .DIV_W(DIV_W)) u_filter (
    .clk(clk), .rst_n(rst_int_n), .close_i(close), .loop_on_i(!ctrl.loop_off),
    .sum_i(sum), .cnt_i(cnt), .div_i(div), .div_wr_i(div_wr), .corr_o(corr));

  clamp_dout #(.PIX_W(PIX_W)) u_dout (
    .clk(clk), .rst_n(rst_int_n), .pix_valid(pix_valid), .pix_code(pix_code),
    .blank(blank), .blank_to_tgt(ctrl.blank_to_tgt), .tgt_i(tgt), .dout(dout));

  assign dac_code = ctrl.loop_off ? tgt[DAC_W-1:0] : corr;

  assert_open_loop_code_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctrl.loop_off |-> dac_code == tgt[DAC_W-1:0]);
endmodule

// File: tb/black_clamp_loop_test.sv
module black_clamp_loop_test;
  logic clk = 1'b0;
  logic rst_n, pix_valid, clamp_win, blank, cfg_we;
  logic [11:0] pix_code, cfg_wdata;
  logic [1:0] cfg_addr;
  logic [9:0] dac_code;
  logic [11:0] dout;

  int checks = 0, fails = 0;
  bit done = 0;
  int exp_corr = 512, exp_tgt = 0, exp_div = 0, exp_line = 0;
  bit exp_off = 0;

  always #10 clk = ~clk;

  black_clamp_loop uut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_code(pix_code),
    .clamp_win(clamp_win), .blank(blank), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dac_code(dac_code), .dout(dout));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_step(int sum, int cnt);
    int r = (65536 + cnt / 2) / cnt;
    int mean = (sum * r) >>> 16;
    return mean >>> 2;
  endfunction

  function automatic void model_close(int sum, int cnt);
    int n;
    if (exp_off) return;
    if (exp_line == exp_div) begin
      exp_line = 0;
      if (cnt > 0) begin
        n = exp_corr - model_step(sum, cnt);
        exp_corr = (n < 0) ? 0 : (n > 1023) ? 1023 : n;
      end
    end else exp_line++;
  endfunction

  task automatic drive(bit v, int code, bit w, bit b);
    pix_valid = v; pix_code = 12'(code); clamp_win = w; blank = b;
    @(negedge clk);
  endtask

  task automatic wr(int addr, int data);
    cfg_we = 1; cfg_addr = 2'(addr); cfg_wdata = 12'(data);
    @(negedge clk);
    cfg_we = 0;
    if (addr == 1) exp_tgt = data;
    if (addr == 2) begin exp_div = data; exp_line = 0; end
    if (addr == 0) exp_off = data[2];
    repeat (2) @(negedge clk);
  endtask

  task automatic window(int n, int code, bit v, int wr_at, int wr_val);
    int cnt = 0;
    for (int i = 0; i < n; i++) begin
      if (i == wr_at) begin cfg_we = 1; cfg_addr = 2'd1; cfg_wdata = 12'(wr_val); end
      drive(v, code, 1, 0);
      cfg_we = 0;
      if (v && cnt < 63) cnt++;
    end
    drive(0, 0, 0, 0);
    model_close(cnt * (code - exp_tgt), cnt);
    if (wr_at >= 0 && wr_at < n) exp_tgt = wr_val;
  endtask

  task automatic t_reset;
    check("R1 dac reset", dac_code, 512);
    check("R1 dout reset", dout, 0);
  endtask

  task automatic t_basic;
    wr(1, 64);
    for (int i = 0; i < 5; i++) drive(1, 3000, 0, 0);
    drive(0, 0, 0, 0);
    check("R2 outside window ignored", dac_code, 512);
    window(20, 104, 1, -1, 0);
    check("R3 positive error step", dac_code, exp_corr);
    check("R3 value 502", dac_code, 502);
    window(16, 27, 1, -1, 0);
    check("R3 negative error step", dac_code, exp_corr);
  endtask

  task automatic t_empty;
    window(5, 4000, 0, -1, 0);
    check("R5 empty window", dac_code, exp_corr);
  endtask

  task automatic t_sat;
    wr(1, 4095);
    window(1, 0, 1, -1, 0);
    check("R4 upper limit", dac_code, 1023);
    wr(1, 0);
    window(1, 4095, 1, -1, 0);
    check("R4 lower limit", dac_code, 0);
    window(1, 4095, 1, -1, 0);
    check("R4 stays at 0", dac_code, 0);
  endtask

  task automatic t_div;
    wr(1, 200);
    wr(2, 2);
    window(20, 160, 1, -1, 0);
    check("R6 skipped close 1", dac_code, 0);
    window(20, 160, 1, -1, 0);
    check("R6 skipped close 2", dac_code, 0);
    window(20, 120, 1, -1, 0);
    check("R6 applied close 3", dac_code, exp_corr);
    check("R6 third window used", dac_code, 21);
    wr(2, 0);
  endtask

  task automatic t_off;
    int held = exp_corr;
    wr(0, 4);
    wr(1, 12'h155);
    check("R7 open loop code", dac_code, 12'h155 & 10'h3ff);
    window(20, 1000, 1, -1, 0);
    check("R7 open loop ignores close", dac_code, 12'h155 & 10'h3ff);
    wr(0, 0);
    check("R7 held correction returns", dac_code, held);
  endtask

  task automatic t_blank;
    drive(1, 77, 0, 1);
    check("R8 blank to zero", dout, 0);
    wr(0, 1);
    drive(1, 77, 0, 1);
    check("R8 blank to target", dout, exp_tgt);
    drive(1, 12'h07A, 0, 0);
    check("R9 sample latched", dout, 12'h07A);
    drive(0, 12'h555, 0, 0);
    drive(0, 12'h0AA, 0, 1);
    check("R9 hold without valid", dout, 12'h07A);
  endtask

  task automatic t_midwrite;
    window(16, exp_tgt + 8, 1, 4, exp_tgt + 100);
    check("R10 old target for whole window", dac_code, exp_corr);
    repeat (2) @(negedge clk);
    drive(1, 5, 0, 1);
    check("R10 new target after close", dout, exp_tgt);
  endtask

  task automatic t_cap;
    window(70, exp_tgt + 63, 1, -1, 0);
    check("R11 count capped at 63", dac_code, exp_corr);
  endtask

  initial begin
    rst_n = 0; pix_valid = 0; pix_code = 0; clamp_win = 0; blank = 0;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_empty();
    t_sat();
    t_div();
    t_off();
    t_blank();
    t_midwrite();
    t_cap();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule